// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block sits between a byte-producing host and a parallel EEPROM. It takes write requests over a ready/valid handshake: an address, a data byte and a flag that marks the final byte of a page. Each request becomes one write cycle on the memory pins. Write enable is the controlling strobe: chip select opens the cycle before write enable falls and closes it after write enable rises. Output enable stays high for the whole time.

All memory timing minimums are given as nanosecond parameters. The block converts each one to a whole number of clock cycles, rounding up, from a clock-period parameter. Three time scales come from the same clock:
- nanosecond strobe timing,
- the microsecond page deadline between consecutive write-enable falling edges,
- the millisecond write-cycle wait after a page closes.

Bytes of a page go out back to back as long as the host keeps up. If the host is late and the page deadline would be missed, the block closes the page by itself. It pulses an expiry flag and then runs the full write-cycle wait.

Top module: `eeprom_page_writer`

Cycle counts used below, with P the clock period:
- LEAD = max(ceil(chip-select setup / P), ceil(address setup / P), 1).
- PULSE = max(ceil(write pulse / P), ceil(data setup / P) − LEAD, 1).
- TRAIL = max(ceil(write-high / P), ceil(data hold / P), ceil(chip-select hold / P), ceil(address hold / P) − PULSE, 1).
- PAGE = ceil(page window / P).
- WAIT = ceil(write-cycle time / P).

Every ceiling is at least 1.

## Requirements
- R1: While reset is held and in the first cycle after it, ee_cs_n, ee_we_n and ee_oe_n are 1, req_ready is 1 and page_expired is 0.
- R2: ee_oe_n is 1 in every cycle.
- R3: For each byte, ee_cs_n is 0 for exactly LEAD cycles with ee_we_n high before ee_we_n falls. It then stays 0 for exactly TRAIL cycles after ee_we_n rises, and only then returns to 1.
- R4: ee_we_n stays 0 for exactly PULSE cycles per byte, which is never fewer than the write-pulse minimum.
- R5: ee_addr and ee_data carry the address and data of the accepted request and do not change while ee_cs_n is 0.
- R6: Between two write pulses of one page, ee_we_n stays high for at least the write-high minimum. When the next byte is waiting, this is exactly TRAIL + 1 + LEAD cycles.
- R7: Within a page, consecutive ee_we_n falling edges are fewer than PAGE cycles apart. A byte presented up to PAGE − LEAD − 2 cycles after the last falling edge is accepted. Presented at that latest point, it falls exactly PAGE − 1 cycles after the previous fall.
- R8: After a byte flagged last, ee_cs_n is 1 and req_ready is 0 for exactly WAIT cycles. After that, req_ready returns to 1.
- R9: If a page has no next byte by PAGE − LEAD − 1 cycles after its last falling edge, page_expired is 1 for exactly one cycle in that cycle, with req_ready 0. Then the WAIT-cycle wait follows.
- R10: A request is accepted only in a cycle where req_valid and req_ready are both 1. req_ready is 0 whenever ee_cs_n is 0 and during the write-cycle wait, so a held request is not issued there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host presents a byte |
| req_ready | output | 1 | Block accepts the byte this cycle |
| req_addr | input | AW | Byte address |
| req_data | input | DW | Byte value |
| req_last | input | 1 | Byte closes the page |
| ee_cs_n | output | 1 | Memory chip select, active low |
| ee_we_n | output | 1 | Memory write enable, active low |
| ee_oe_n | output | 1 | Memory output enable, held high |
| ee_addr | output | AW | Memory address bus |
| ee_data | output | DW | Memory data bus (driven only) |
| page_expired | output | 1 | One-cycle pulse when a page closes by deadline |

## Verification
The phase timer and the state register both shape the strobes, so an error in either shows up on the very next write pulse as a wrong lead, pulse or trail length on ee_cs_n and ee_we_n. An error in the page-window counter shows up one page later: either the spacing between two falling edges is wrong, or page_expired fires in the wrong cycle or not at all. An error in the long wait counter stays hidden until the page closes. It then shows as req_ready returning early or late, measured to the exact cycle. A wrong capture register corrupts ee_addr or ee_data at the next falling edge.

// File: rtl/epw_pkg.sv
`timescale 1ns/1ps
package epw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_PULSE,
      ST_TRAIL,
      ST_PAGE,
      ST_WAIT
   } epw_state_e;

   // Convert a duration in ns to clock cycles, rounded up, never below one.
   function automatic int unsigned epw_cycles(int unsigned dur_ns, int unsigned period_ps);
      logic [63:0] num;
      logic [63:0] cyc;
      num = 64'(dur_ns) * 64'd1000 + 64'(period_ps) - 64'd1;
      cyc = num / 64'(period_ps);
      if (cyc == 64'd0) cyc = 64'd1;
      return 32'(cyc);
   endfunction

   function automatic int unsigned epw_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned epw_sub_floor1(int unsigned a, int unsigned b);
      return (a > b) ? (a - b) : 1;
   endfunction

endpackage

// File: rtl/epw_phase_timer.sv
`timescale 1ns/1ps
module epw_phase_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] value,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= value;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/epw_page_window.sv
`timescale 1ns/1ps
module epw_page_window #(
   parameter int unsigned LAST_OK = 47
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic open
);
   localparam int unsigned SAT = LAST_OK + 1;
   localparam int unsigned CW  = $clog2(SAT + 1);

   logic [CW-1:0] elapsed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= CW'(SAT);
      end else if (restart) begin
         elapsed_q <= '0;
      end else if (elapsed_q != CW'(SAT)) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   assign open = (elapsed_q <= CW'(LAST_OK));
endmodule

// File: rtl/epw_bus_latch.sv
`timescale 1ns/1ps
module epw_bus_latch #(
   parameter int unsigned AW            = 17,
   parameter int unsigned DW            = 8,
   parameter bit          HOLD_BUS_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          bus_active,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic [AW-1:0] addr_out,
   output logic [DW-1:0] data_out
);
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   generate
      if (HOLD_BUS_IDLE) begin : g_hold
         logic unused_active;
         assign unused_active = bus_active;
         assign addr_out      = addr_q;
         assign data_out      = data_q;
      end else begin : g_park
         assign addr_out = bus_active ? addr_q : '0;
         assign data_out = bus_active ? data_q : '0;
      end
   endgenerate
endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer
   import epw_pkg::*;
#(
   parameter int unsigned AW            = 17,
   parameter int unsigned DW            = 8,
   parameter int unsigned CLK_PERIOD_PS = 20000,
   parameter int unsigned T_AS_NS       = 0,
   parameter int unsigned T_CS_SU_NS    = 0,
   parameter int unsigned T_WP_NS       = 100,
   parameter int unsigned T_DS_NS       = 50,
   parameter int unsigned T_DH_NS       = 10,
   parameter int unsigned T_AH_NS       = 100,
   parameter int unsigned T_CSH_NS      = 0,
   parameter int unsigned T_WPH_NS      = 50,
   parameter int unsigned T_PAGE_NS     = 150000,
   parameter int unsigned T_WC_NS       = 10000000,
   parameter bit          HOLD_BUS_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_last,
   output logic          ee_cs_n,
   output logic          ee_we_n,
   output logic          ee_oe_n,
   output logic [AW-1:0] ee_addr,
   output logic [DW-1:0] ee_data,
   output logic          page_expired
);
   // Phase lengths in cycles
   localparam int unsigned LEAD_CYC  = epw_max(epw_cycles(T_CS_SU_NS, CLK_PERIOD_PS),
                                               epw_cycles(T_AS_NS, CLK_PERIOD_PS));
   localparam int unsigned PULSE_CYC = epw_max(epw_cycles(T_WP_NS, CLK_PERIOD_PS),
                                               epw_sub_floor1(epw_cycles(T_DS_NS, CLK_PERIOD_PS), LEAD_CYC));
   localparam int unsigned TRAIL_CYC = epw_max(
                                          epw_max(epw_cycles(T_WPH_NS, CLK_PERIOD_PS),
                                                  epw_cycles(T_DH_NS, CLK_PERIOD_PS)),
                                          epw_max(epw_cycles(T_CSH_NS, CLK_PERIOD_PS),
                                                  epw_sub_floor1(epw_cycles(T_AH_NS, CLK_PERIOD_PS), PULSE_CYC)));
   localparam int unsigned PAGE_CYC  = epw_cycles(T_PAGE_NS, CLK_PERIOD_PS);
   localparam int unsigned WC_CYC    = epw_cycles(T_WC_NS, CLK_PERIOD_PS);
   localparam int unsigned LAST_OK   = PAGE_CYC - LEAD_CYC - 2;
   localparam int unsigned TMR_MAX   = epw_max(epw_max(WC_CYC, PULSE_CYC), epw_max(TRAIL_CYC, LEAD_CYC));
   localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);

   // Elaboration-time parameter checks
   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("eeprom_page_writer: bus widths must be at least 1");
      end
      if (CLK_PERIOD_PS == 0) begin : g_bad_clock
         $error("eeprom_page_writer: clock period must be nonzero");
      end
      if (PAGE_CYC <= LEAD_CYC + PULSE_CYC + TRAIL_CYC + 2) begin : g_bad_page
         $error("eeprom_page_writer: page window too short for one byte cycle");
      end
   endgenerate

   epw_state_e state_q, state_d;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_done;
   logic             win_open;
   logic             win_restart;
   logic             accept;
   logic             last_q;
   logic             cs_n_q, we_n_q;

   assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_PAGE) && win_open);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_d  = ST_LEAD;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(LEAD_CYC - 1);
            end
         end
         ST_LEAD: begin
            if (tmr_done) begin
               state_d  = ST_PULSE;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(PULSE_CYC - 1);
            end
         end
         ST_PULSE: begin
            if (tmr_done) begin
               state_d  = ST_TRAIL;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(TRAIL_CYC - 1);
            end
         end
         ST_TRAIL: begin
            if (tmr_done) begin
               if (last_q) begin
                  state_d  = ST_WAIT;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(WC_CYC - 1);
               end else begin
                  state_d = ST_PAGE;
               end
            end
         end
         ST_PAGE: begin
            if (accept) begin
               state_d  = ST_LEAD;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(LEAD_CYC - 1);
            end else if (!win_open) begin
               state_d  = ST_WAIT;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(WC_CYC - 1);
            end
         end
         ST_WAIT: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         last_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         if (accept) last_q <= req_last;
         cs_n_q  <= !((state_d == ST_LEAD) || (state_d == ST_PULSE) || (state_d == ST_TRAIL));
         we_n_q  <= (state_d != ST_PULSE);
      end
   end

   assign win_restart = (state_d == ST_PULSE) && (state_q != ST_PULSE);

   epw_phase_timer #(.W(TMR_W)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .value (tmr_val),
      .done  (tmr_done)
   );

   epw_page_window #(.LAST_OK(LAST_OK)) i_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (win_restart),
      .open    (win_open)
   );

   epw_bus_latch #(.AW(AW), .DW(DW), .HOLD_BUS_IDLE(HOLD_BUS_IDLE)) i_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .bus_active (!cs_n_q),
      .addr_in    (req_addr),
      .data_in    (req_data),
      .addr_out   (ee_addr),
      .data_out   (ee_data)
   );

   assign ee_cs_n      = cs_n_q;
   assign ee_we_n      = we_n_q;
   assign ee_oe_n      = 1'b1;
   assign page_expired = (state_q == ST_PAGE) && !win_open;
endmodule

// File: rtl/epw_checker.sv
`timescale 1ns/1ps
module epw_checker
   import epw_pkg::*;
#(
   parameter int unsigned AW            = 17,
   parameter int unsigned DW            = 8,
   parameter int unsigned CLK_PERIOD_PS = 20000,
   parameter int unsigned T_WP_NS       = 100,
   parameter int unsigned T_WPH_NS      = 50,
   parameter int unsigned T_PAGE_NS     = 150000,
   parameter int unsigned T_WC_NS       = 10000000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          ee_cs_n,
   input logic          ee_we_n,
   input logic [AW-1:0] ee_addr,
   input logic [DW-1:0] ee_data,
   input logic          page_expired
);
   localparam int unsigned WP_CYC   = epw_cycles(T_WP_NS, CLK_PERIOD_PS);
   localparam int unsigned WPH_CYC  = epw_cycles(T_WPH_NS, CLK_PERIOD_PS);
   localparam int unsigned PAGE_CYC = epw_cycles(T_PAGE_NS, CLK_PERIOD_PS);
   localparam int unsigned WC_CYC   = epw_cycles(T_WC_NS, CLK_PERIOD_PS);

   int unsigned low_len, high_len, since_fall, wait_len;
   logic        we_d, page_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_len    <= 0;
         high_len   <= 0;
         since_fall <= 0;
         wait_len   <= 0;
         we_d       <= 1'b1;
         page_open  <= 1'b0;
      end else begin
         we_d     <= ee_we_n;
         low_len  <= ee_we_n ? 0 : low_len + 1;
         high_len <= ee_we_n ? high_len + 1 : 0;
         if (!ee_we_n && we_d)                     since_fall <= 1;
         else if (since_fall != 32'hFFFF_FFFF)     since_fall <= since_fall + 1;
         wait_len <= (ee_cs_n && !req_ready) ? wait_len + 1 : 0;
         if (!ee_we_n && we_d)                     page_open <= 1'b1;
         else if (ee_cs_n && !req_ready)           page_open <= 1'b0;
      end
   end

   p_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_we_n) |-> !ee_cs_n && !$past(ee_cs_n));

   p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs_n) |-> ee_we_n && $past(ee_we_n));

   p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_we_n) |-> low_len >= WP_CYC);

   p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ee_cs_n && !$past(ee_cs_n)) |-> ($stable(ee_addr) && $stable(ee_data)));

   p_high_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ee_we_n) && page_open) |-> high_len >= WPH_CYC);

   p_page_deadline_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ee_we_n) && page_open) |-> since_fall < PAGE_CYC);

   p_cycle_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_ready) && $past(ee_cs_n)) |-> wait_len >= WC_CYC);

   p_expired_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      page_expired |=> !page_expired);

   p_expired_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      page_expired |-> (!req_ready && ee_cs_n));

   p_ready_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs_n |-> !req_ready);
endmodule

bind eeprom_page_writer epw_checker #(
   .AW            (AW),
   .DW            (DW),
   .CLK_PERIOD_PS (CLK_PERIOD_PS),
   .T_WP_NS       (T_WP_NS),
   .T_WPH_NS      (T_WPH_NS),
   .T_PAGE_NS     (T_PAGE_NS),
   .T_WC_NS       (T_WC_NS)
) i_epw_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .ee_cs_n      (ee_cs_n),
   .ee_we_n      (ee_we_n),
   .ee_addr      (ee_addr),
   .ee_data      (ee_data),
   .page_expired (page_expired)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;
   localparam int AW = 17;
   localparam int DW = 8;
   // Expected cycle counts at 20 ns: lead 1, pulse 5 (100 ns), trail 3 (50 ns high),
   // page window 50 (1000 ns), write-cycle wait 100 (2000 ns).
   localparam int E_LEAD  = 1;
   localparam int E_PULSE = 5;
   localparam int E_TRAIL = 3;
   localparam int E_WPH   = 3;
   localparam int E_PAGE  = 50;
   localparam int E_WC    = 100;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_ready, req_last;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          ee_cs_n, ee_we_n, ee_oe_n, page_expired;
   logic [AW-1:0] ee_addr;
   logic [DW-1:0] ee_data;

   always #10 clk = ~clk;

   eeprom_page_writer #(
      .AW(AW), .DW(DW), .CLK_PERIOD_PS(20000),
      .T_PAGE_NS(1000), .T_WC_NS(2000)
   ) i_eeprom_page_writer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
      .ee_cs_n(ee_cs_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n),
      .ee_addr(ee_addr), .ee_data(ee_data), .page_expired(page_expired)
   );

   int vecs = 0;
   int bad  = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      vecs++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Port monitor, sampled on the falling clock edge
   int          cyc = 0, nfall = 0, last_fall = 0;
   int          low_cnt = 0, high_cnt = 0, lead_cnt = 0, trail_cnt = 0, trail_last = 0;
   int          oe_err = 0, rdy_err = 0, stab_err = 0, exp_cnt = 0;
   bit          in_trail = 0, prev_we = 1, prev_cs = 1;
   logic [AW-1:0] ref_a;
   logic [DW-1:0] ref_d;
   logic [AW-1:0] cap_a [0:31];
   logic [DW-1:0] cap_d [0:31];
   int          width_a [0:31];
   int          ival_a  [0:31];
   int          gap_a   [0:31];
   int          lead_a  [0:31];

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (ee_oe_n !== 1'b1) oe_err++;
         if (!ee_cs_n && req_ready) rdy_err++;
         if (!ee_cs_n) begin
            if (prev_cs) begin
               ref_a = ee_addr;
               ref_d = ee_data;
            end else if (ee_addr !== ref_a || ee_data !== ref_d) begin
               stab_err++;
            end
         end
         if (!ee_we_n && prev_we) begin
            cap_a[nfall % 32]  = ee_addr;
            cap_d[nfall % 32]  = ee_data;
            ival_a[nfall % 32] = cyc - last_fall;
            gap_a[nfall % 32]  = high_cnt;
            lead_a[nfall % 32] = lead_cnt;
            lead_cnt  = 0;
            last_fall = cyc;
            nfall++;
            low_cnt   = 0;
         end
         if (!ee_we_n) low_cnt++;
         if (ee_we_n && !prev_we) begin
            width_a[(nfall - 1) % 32] = low_cnt;
            in_trail  = 1;
            trail_cnt = 0;
            high_cnt  = 0;
         end
         if (ee_we_n) high_cnt++;
         if (!ee_cs_n && ee_we_n && !in_trail) lead_cnt++;
         if (in_trail && !ee_cs_n && ee_we_n) trail_cnt++;
         if (ee_cs_n && !prev_cs) begin
            trail_last = trail_cnt;
            in_trail   = 0;
         end
         if (page_expired) exp_cnt++;
         prev_we = ee_we_n;
         prev_cs = ee_cs_n;
      end
   end

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit l);
      req_valid = 1'b1;
      req_addr  = a;
      req_data  = d;
      req_last  = l;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_close(input string tag);
      int n;
      while (ee_cs_n) @(negedge clk);
      while (!ee_cs_n) @(negedge clk);
      n = 0;
      while (!req_ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
      check(n == E_WC, tag, n, E_WC);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_last = 1'b0; req_addr = '0; req_data = '0;
      repeat (3) @(negedge clk);
      check(ee_cs_n && ee_we_n && ee_oe_n, "R1 strobes high in reset", {ee_cs_n, ee_we_n, ee_oe_n}, 7);
      rst_n = 1'b1;
      @(negedge clk);
      check(ee_cs_n && ee_we_n && ee_oe_n, "R1 strobes high after reset", {ee_cs_n, ee_we_n, ee_oe_n}, 7);
      check(req_ready && !page_expired, "R1 ready idle", {req_ready, page_expired}, 2);
   endtask

   task automatic t_single();
      int n0 = nfall;
      push(17'h1_2345, 8'hA5, 1'b1);
      wait_close("R8 wait after single byte");
      check(nfall == n0 + 1, "R10 one pulse", nfall - n0, 1);
      check(cap_a[n0 % 32] == 17'h1_2345, "R5 address", cap_a[n0 % 32], 17'h1_2345);
      check(cap_d[n0 % 32] == 8'hA5, "R5 data", cap_d[n0 % 32], 8'hA5);
      check(width_a[n0 % 32] == E_PULSE, "R4 pulse width", width_a[n0 % 32], E_PULSE);
      check(lead_a[n0 % 32] == E_LEAD, "R3 lead", lead_a[n0 % 32], E_LEAD);
      check(trail_last == E_TRAIL, "R3 trail", trail_last, E_TRAIL);
   endtask

   task automatic t_page();
      int n0 = nfall;
      int e0 = exp_cnt;
      for (int i = 0; i < 4; i++)
         push(17'h0_0F00 + 17'(i), 8'h3C ^ 8'(i), i == 3);
      wait_close("R8 wait after page of four");
      check(nfall == n0 + 4, "R10 four pulses", nfall - n0, 4);
      for (int i = 0; i < 4; i++) begin
         check(cap_a[(n0 + i) % 32] == 17'h0_0F00 + 17'(i), "R5 page address",
               cap_a[(n0 + i) % 32], 17'h0_0F00 + i);
         check(cap_d[(n0 + i) % 32] == (8'h3C ^ 8'(i)), "R5 page data",
               cap_d[(n0 + i) % 32], 8'h3C ^ i);
      end
      for (int i = 1; i < 4; i++) begin
         check(ival_a[(n0 + i) % 32] == E_PULSE + E_TRAIL + 1 + E_LEAD && ival_a[(n0 + i) % 32] < E_PAGE,
               "R7 fall spacing", ival_a[(n0 + i) % 32], E_PULSE + E_TRAIL + 1 + E_LEAD);
         check(gap_a[(n0 + i) % 32] == E_TRAIL + 1 + E_LEAD && gap_a[(n0 + i) % 32] >= E_WPH,
               "R6 high gap", gap_a[(n0 + i) % 32], E_TRAIL + 1 + E_LEAD);
      end
      check(exp_cnt == e0, "R9 no expiry in full page", exp_cnt - e0, 0);
   endtask

   task automatic t_edge();
      int n0 = nfall;
      int e0 = exp_cnt;
      push(17'h1_FFF0, 8'h11, 1'b0);
      while (ee_we_n) @(negedge clk);
      repeat (E_PAGE - E_LEAD - 2) @(negedge clk);
      check(req_ready == 1'b1, "R7 window still open", req_ready, 1);
      req_valid = 1'b1; req_addr = 17'h1_FFF1; req_data = 8'h22; req_last = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_close("R8 wait after late page");
      check(nfall == n0 + 2, "R7 late byte issued", nfall - n0, 2);
      check(ival_a[(n0 + 1) % 32] == E_PAGE - 1, "R7 latest fall spacing", ival_a[(n0 + 1) % 32], E_PAGE - 1);
      check(cap_d[(n0 + 1) % 32] == 8'h22, "R5 late data", cap_d[(n0 + 1) % 32], 8'h22);
      check(exp_cnt == e0, "R9 no expiry at latest point", exp_cnt - e0, 0);
   endtask

   task automatic t_timeout();
      int n0 = nfall;
      int e0 = exp_cnt;
      int n;
      push(17'h0_0040, 8'h5A, 1'b0);
      while (ee_we_n) @(negedge clk);
      repeat (E_PAGE - E_LEAD - 2) @(negedge clk);
      check(!page_expired && req_ready, "R9 not yet expired", page_expired, 0);
      @(negedge clk);
      check(page_expired == 1'b1, "R9 expiry cycle", page_expired, 1);
      check(req_ready == 1'b0, "R9 ready low at expiry", req_ready, 0);
      req_valid = 1'b1; req_addr = 17'h0_0080; req_data = 8'hC3; req_last = 1'b1;
      @(negedge clk);
      check(page_expired == 1'b0, "R9 expiry one cycle", page_expired, 0);
      n = 0;
      while (!req_ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
      check(n == E_WC, "R9 wait after expiry", n, E_WC);
      check(nfall == n0 + 1, "R10 held byte not issued during wait", nfall - n0, 1);
      @(negedge clk);
      req_valid = 1'b0;
      wait_close("R8 wait after reopened page");
      check(nfall == n0 + 2, "R10 held byte issued after wait", nfall - n0, 2);
      check(cap_a[(n0 + 1) % 32] == 17'h0_0080, "R5 held address", cap_a[(n0 + 1) % 32], 17'h0_0080);
      check(exp_cnt == e0 + 1, "R9 single expiry", exp_cnt - e0, 1);
   endtask

   initial begin
      t_reset();
      t_single();
      t_page();
      t_edge();
      t_timeout();
      check(oe_err == 0, "R2 output enable high", oe_err, 0);
      check(rdy_err == 0, "R10 ready low while selected", rdy_err, 0);
      check(stab_err == 0, "R5 bus stable while selected", stab_err, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog R10: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule